// File: doc/BRIEF.md
# Multiply-by-243 Residue Error Codec

This block guards a 64-bit data word with an arithmetic code. The encoder multiplies the word by the odd constant 243 and returns a 72-bit codeword, which is what the surrounding memory stores. The decoder accepts a 72-bit codeword read back from storage. It divides the codeword by 243 using a bit-serial restoring divider, which yields the quotient and the residue together. A residue of zero means the quotient is the original data.

A flip of one bit at position k shifts the stored value by plus or minus 2^k. Because 2 generates the units modulo 243, all 144 signed signatures over the 72 codeword positions are distinct and nonzero. A nonzero residue therefore names both the bit position and the direction of the flip. The decoder repairs the codeword and runs a second division to recover the data. A residue that names no single-bit flip consistent with the received bit value is reported as uncorrectable.

Each path has a valid/ready handshake on its input and on its output. The two paths are independent of each other, so encodes can stream while a decode is in progress.

Top module: `ancode_codec`

## Requirements
- R1: After reset, enc_in_ready and dec_in_ready are 1, and enc_out_valid and dec_out_valid are 0.
- R2: A word accepted on the encode input appears on enc_out_cw, equal to the data times 243 as a 72-bit value, with enc_out_valid high from the clock edge that follows acceptance.
- R3: While enc_out_valid is high and enc_out_ready is low, enc_out_cw stays unchanged and enc_in_ready is low. Otherwise enc_in_ready is high.
- R4: When the codeword modulo 243 is 0 and the quotient is below 2^64, the decoder returns the quotient with both flags at 0. The result is valid 73 clock edges after acceptance.
- R5: When the residue equals 2^k mod 243 for a position k (0 to 71) at which the received bit is 1, bit k is cleared. The data returned is the corrected codeword divided by 243, with dec_out_corrected=1. The result is valid 146 edges after acceptance. This applies to the check positions 64 to 71 as well.
- R6: When the residue equals 243 minus (2^k mod 243) for a position k at which the received bit is 0, bit k is set. The data and timing are as in R5, with dec_out_corrected=1.
- R7: A nonzero residue that meets neither R5 nor R6 gives dec_out_uncorrectable=1, dec_out_corrected=0 and data 0. The result is valid 73 edges after acceptance.
- R8: When the quotient (after any correction) is 2^64 or larger, the result is dec_out_uncorrectable=1, dec_out_corrected=0 and data 0. The timing follows R4, or R5/R6 if a correction was made.
- R9: dec_in_ready is 0 from the edge that accepts a codeword until the edge that completes the output handshake. While dec_out_valid is high and dec_out_ready is low, the decode outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Data word offered for encoding |
| enc_in_ready | output | 1 | Encoder can take a word |
| enc_in_data | input | 64 | Data word to encode |
| enc_out_valid | output | 1 | Codeword available |
| enc_out_ready | input | 1 | Consumer takes the codeword |
| enc_out_cw | output | 72 | Data times 243 |
| dec_in_valid | input | 1 | Codeword offered for decoding |
| dec_in_ready | output | 1 | Decoder is idle |
| dec_in_cw | input | 72 | Codeword read from storage |
| dec_out_valid | output | 1 | Decode result available |
| dec_out_ready | input | 1 | Consumer takes the result |
| dec_out_data | output | 64 | Recovered data word, 0 if uncorrectable |
| dec_out_corrected | output | 1 | A single-bit flip was repaired |
| dec_out_uncorrectable | output | 1 | The error could not be repaired |

## Verification
An encode result is due one edge after its input handshake. A decode result is due 73 edges after acceptance, or 146 edges when a repair pass runs.

The bench keeps a behavioural model that counts these edges down per decode and holds the encoder result register. It compares every output with the model at each falling clock edge, so a result that arrives one cycle early or late is caught on the cycle in which it appears. Ready signals on both output sides are toggled at random, which exercises the holding behaviour during every result phase.

// File: rtl/ancode_pkg.sv
package ancode_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV1 = 2'd1,
        ST_DIV2 = 2'd2,
        ST_OUT  = 2'd3
    } dec_state_e;

    // 2^k reduced modulo m, evaluated at elaboration time
    function automatic int pow2_mod(input int k, input int m);
        int r;
        r = 1 % m;
        for (int i = 0; i < k; i++) begin
            r = (r * 2) % m;
        end
        return r;
    endfunction

endpackage

// File: rtl/ancode_divider.sv
module ancode_divider #(
    parameter int CW_W  = 72,
    parameter int MOD   = 243,
    parameter int REM_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CW_W-1:0]  dividend_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CW_W-1:0]  quot_o,
    output logic [REM_W-1:0] rem_o
);
    localparam int CNT_W = $clog2(CW_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [CW_W-1:0]  num;
        logic [CW_W-1:0]  quo;
        logic [REM_W-1:0] rem;
    } div_t;

    div_t div_d, div_q;
    logic [REM_W-1:0] trial;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = {div_q.rem[REM_W-2:0], div_q.num[CW_W-1]};
        if (start_i) begin
            div_d.busy = 1'b1;
            div_d.cnt  = CNT_W'(CW_W);
            div_d.num  = dividend_i;
            div_d.quo  = '0;
            div_d.rem  = '0;
        end else if (div_q.busy) begin
            div_d.num = {div_q.num[CW_W-2:0], 1'b0};
            if (trial >= REM_W'(MOD)) begin
                div_d.rem = trial - REM_W'(MOD);
                div_d.quo = {div_q.quo[CW_W-2:0], 1'b1};
            end else begin
                div_d.rem = trial;
                div_d.quo = {div_q.quo[CW_W-2:0], 1'b0};
            end
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign busy_o = div_q.busy;
    assign done_o = div_q.done;
    assign quot_o = div_q.quo;
    assign rem_o  = div_q.rem;

    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rem_o < REM_W'(MOD)) && !busy_o); // R4

endmodule

// File: rtl/ancode_locator.sv
module ancode_locator #(
    parameter int CW_W  = 72,
    parameter int MOD   = 243,
    parameter int REM_W = 9
) (
    input  logic [REM_W-1:0] rem_i,
    input  logic [CW_W-1:0]  cw_i,
    output logic             hit_o,
    output logic [CW_W-1:0]  flip_o
);
    import ancode_pkg::*;

    logic [CW_W-1:0] up_hit;
    logic [CW_W-1:0] dn_hit;

    for (genvar k = 0; k < CW_W; k++) begin : g_sig
        localparam int SIG_UP = pow2_mod(k, MOD);
        localparam int SIG_DN = MOD - SIG_UP;
        // bit went 0->1: value grew by 2^k, bit now reads 1
        assign up_hit[k] = (rem_i == REM_W'(SIG_UP)) && cw_i[k];
        // bit went 1->0: value shrank by 2^k, bit now reads 0
        assign dn_hit[k] = (rem_i == REM_W'(SIG_DN)) && !cw_i[k];
    end

    assign flip_o = up_hit | dn_hit;
    assign hit_o  = |flip_o;

endmodule

// File: rtl/ancode_encoder.sv
module ancode_encoder #(
    parameter int DATA_W = 64,
    parameter int CW_W   = 72,
    parameter int MOD    = 243
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CW_W-1:0]   out_cw
);
    typedef struct packed {
        logic            valid;
        logic [CW_W-1:0] cw;
    } enc_t;

    enc_t enc_d, enc_q;

    always_comb begin
        enc_d    = enc_q;
        in_ready = !enc_q.valid || out_ready;
        if (in_ready) begin
            enc_d.valid = in_valid;
            if (in_valid) begin
                enc_d.cw = CW_W'(in_data) * CW_W'(MOD);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) enc_q <= '0;
        else        enc_q <= enc_d;
    end

    assign out_valid = enc_q.valid;
    assign out_cw    = enc_q.cw;

    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_cw)); // R3

endmodule

// File: rtl/ancode_codec.sv
module ancode_codec #(
    parameter int DATA_W = 64,
    parameter int MOD    = 243,
    parameter int CW_W   = 72
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_in_valid,
    output logic              enc_in_ready,
    input  logic [DATA_W-1:0] enc_in_data,
    output logic              enc_out_valid,
    input  logic              enc_out_ready,
    output logic [CW_W-1:0]   enc_out_cw,
    input  logic              dec_in_valid,
    output logic              dec_in_ready,
    input  logic [CW_W-1:0]   dec_in_cw,
    output logic              dec_out_valid,
    input  logic              dec_out_ready,
    output logic [DATA_W-1:0] dec_out_data,
    output logic              dec_out_corrected,
    output logic              dec_out_uncorrectable
);
    import ancode_pkg::*;

    localparam int REM_W = $clog2(MOD) + 1;

    typedef struct packed {
        dec_state_e        state;
        logic [CW_W-1:0]   cw;
        logic [DATA_W-1:0] data;
        logic              corr;
        logic              unc;
    } dec_t;

    dec_t dec_d, dec_q;

    logic             div_start;
    logic [CW_W-1:0]  div_dividend;
    logic             div_busy;
    logic             div_done;
    logic [CW_W-1:0]  div_quo;
    logic [REM_W-1:0] div_rem;
    logic             loc_hit;
    logic [CW_W-1:0]  loc_flip;
    logic             quo_big;

    ancode_encoder #(.DATA_W(DATA_W), .CW_W(CW_W), .MOD(MOD)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_in_data),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_cw    (enc_out_cw)
    );

    ancode_divider #(.CW_W(CW_W), .MOD(MOD), .REM_W(REM_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (div_start),
        .dividend_i (div_dividend),
        .busy_o     (div_busy),
        .done_o     (div_done),
        .quot_o     (div_quo),
        .rem_o      (div_rem)
    );

    ancode_locator #(.CW_W(CW_W), .MOD(MOD), .REM_W(REM_W)) u_loc (
        .rem_i  (div_rem),
        .cw_i   (dec_q.cw),
        .hit_o  (loc_hit),
        .flip_o (loc_flip)
    );

    assign quo_big = |div_quo[CW_W-1:DATA_W];

    always_comb begin
        dec_d        = dec_q;
        div_start    = 1'b0;
        div_dividend = dec_in_cw;
        unique case (dec_q.state)
            ST_IDLE: begin
                if (dec_in_valid) begin
                    dec_d.cw    = dec_in_cw;
                    dec_d.state = ST_DIV1;
                    div_start   = 1'b1;
                end
            end
            ST_DIV1: begin
                if (div_done) begin
                    if (div_rem == '0) begin
                        dec_d.state = ST_OUT;
                        dec_d.data  = quo_big ? '0 : div_quo[DATA_W-1:0];
                        dec_d.corr  = 1'b0;
                        dec_d.unc   = quo_big;
                    end else if (loc_hit) begin
                        dec_d.cw     = dec_q.cw ^ loc_flip;
                        dec_d.state  = ST_DIV2;
                        div_dividend = dec_q.cw ^ loc_flip;
                        div_start    = 1'b1;
                    end else begin
                        dec_d.state = ST_OUT;
                        dec_d.data  = '0;
                        dec_d.corr  = 1'b0;
                        dec_d.unc   = 1'b1;
                    end
                end
            end
            ST_DIV2: begin
                if (div_done) begin
                    dec_d.state = ST_OUT;
                    dec_d.data  = quo_big ? '0 : div_quo[DATA_W-1:0];
                    dec_d.corr  = !quo_big;
                    dec_d.unc   = quo_big;
                end
            end
            ST_OUT: begin
                if (dec_out_ready) dec_d.state = ST_IDLE;
            end
            default: dec_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q       <= '0;
            dec_q.state <= ST_IDLE;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign dec_in_ready          = (dec_q.state == ST_IDLE);
    assign dec_out_valid         = (dec_q.state == ST_OUT);
    assign dec_out_data          = dec_q.data;
    assign dec_out_corrected     = dec_q.corr;
    assign dec_out_uncorrectable = dec_q.unc;

    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_data)
        && $stable(dec_out_corrected) && $stable(dec_out_uncorrectable)); // R9
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        div_busy |-> !dec_in_ready && !dec_out_valid); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid |-> !(dec_out_corrected && dec_out_uncorrectable)); // R7
    AST_UNC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && dec_out_uncorrectable |-> dec_out_data == '0); // R8
    AST_FIX_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_q.state == ST_DIV2) && div_done |-> div_rem == '0); // R5
    AST_FLIP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(loc_flip)); // R6

endmodule

// File: tb/ancode_codec_test.sv
module ancode_codec_test;
    localparam int CW    = 72;
    localparam int LAT1  = CW + 1;
    localparam int LAT2  = 2 * (CW + 1);
    localparam int NCYC  = 14000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_in_valid = 1'b0;
    logic        enc_in_ready;
    logic [63:0] enc_in_data = '0;
    logic        enc_out_valid;
    logic        enc_out_ready = 1'b0;
    logic [71:0] enc_out_cw;
    logic        dec_in_valid = 1'b0;
    logic        dec_in_ready;
    logic [71:0] dec_in_cw = '0;
    logic        dec_out_valid;
    logic        dec_out_ready = 1'b0;
    logic [63:0] dec_out_data;
    logic        dec_out_corrected;
    logic        dec_out_uncorrectable;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ancode_codec uut (
        .clk                   (clk),
        .rst_n                 (rst_n),
        .enc_in_valid          (enc_in_valid),
        .enc_in_ready          (enc_in_ready),
        .enc_in_data           (enc_in_data),
        .enc_out_valid         (enc_out_valid),
        .enc_out_ready         (enc_out_ready),
        .enc_out_cw            (enc_out_cw),
        .dec_in_valid          (dec_in_valid),
        .dec_in_ready          (dec_in_ready),
        .dec_in_cw             (dec_in_cw),
        .dec_out_valid         (dec_out_valid),
        .dec_out_ready         (dec_out_ready),
        .dec_out_data          (dec_out_data),
        .dec_out_corrected     (dec_out_corrected),
        .dec_out_uncorrectable (dec_out_uncorrectable)
    );

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference: decode result and latency from the requirement text
    task automatic predict(input logic [71:0] cw, output logic [63:0] data, output bit corr,
                           output bit unc, output int lat, output string tag);
        logic [71:0] fixed, quo;
        int          r, sig;
        bit          found;
        fixed = cw;
        r     = int'(cw % 72'd243);
        found = 1'b0;
        lat   = LAT1;
        corr  = 1'b0;
        unc   = 1'b0;
        tag   = "R4";
        if (r != 0) begin
            for (int k = 0; k < CW; k++) begin
                sig = 1;
                for (int i = 0; i < k; i++) sig = (sig * 2) % 243;
                if (!found && sig == r && cw[k]) begin
                    found = 1'b1; fixed = cw - (72'd1 << k); tag = "R5";
                end else if (!found && (243 - sig) == r && !cw[k]) begin
                    found = 1'b1; fixed = cw + (72'd1 << k); tag = "R6";
                end
            end
            if (found) begin
                lat = LAT2; corr = 1'b1;
            end else begin
                unc = 1'b1; tag = "R7";
            end
        end
        quo  = fixed / 72'd243;
        data = quo[63:0];
        if (!unc && quo[71:64] != 8'd0) begin
            unc = 1'b1; corr = 1'b0; tag = "R8";
        end
        if (unc) data = '0;
    endtask

    function automatic logic [71:0] make_case(input int i);
        logic [63:0] d;
        logic [71:0] cw;
        int          k, j;
        d  = {$urandom, $urandom};
        cw = 72'(d) * 72'd243;
        case (i % 9)
            0: cw = '0;
            1: cw = 72'(64'hFFFF_FFFF_FFFF_FFFF) * 72'd243;
            2: ;
            3: begin // R5: a zero bit turned to one
                k = $urandom % 64;
                for (int s = 0; s < CW; s++) if (cw[(k + s) % CW] == 1'b0) j = (k + s) % CW;
                cw[j] = 1'b1;
            end
            4: begin // R6: a one bit turned to zero
                k = $urandom % 64;
                for (int s = 0; s < CW; s++) if (cw[(k + s) % CW] == 1'b1) j = (k + s) % CW;
                cw[j] = 1'b0;
            end
            5: begin // R5 R6 in the check positions
                k = 64 + ($urandom % 8);
                cw[k] = ~cw[k];
            end
            6: begin // R7: two flips
                k = $urandom % 72;
                j = (k + 1 + ($urandom % 70)) % 72;
                cw[k] = ~cw[k];
                cw[j] = ~cw[j];
            end
            7: cw = ((72'd1 << 64) | 72'($urandom)) * 72'd243; // R8
            default: cw = {$urandom, $urandom, $urandom} & {8'hFF, 64'hFFFF_FFFF_FFFF_FFFF};
        endcase
        return cw;
    endfunction

    // model state
    bit          m_ev = 1'b0;
    logic [71:0] m_ecw = '0;
    int          m_ds = 0;
    int          m_cnt = 0;
    logic [63:0] m_data = '0;
    bit          m_corr = 1'b0;
    bit          m_unc = 1'b0;
    string       m_tag = "R4";
    bit          have_case = 1'b0;
    logic [71:0] case_cw = '0;
    int          case_idx = 0;
    int          n_dec = 0;

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(enc_in_ready == 1'b1, "R1 enc_in_ready", 72'(enc_in_ready), 72'd1);
        chk(dec_in_ready == 1'b1, "R1 dec_in_ready", 72'(dec_in_ready), 72'd1);
        chk(enc_out_valid == 1'b0, "R1 enc_out_valid", 72'(enc_out_valid), 72'd0);
        chk(dec_out_valid == 1'b0, "R1 dec_out_valid", 72'(dec_out_valid), 72'd0);
        for (int c = 0; c < NCYC; c++) begin
            if (c != 0) @(negedge clk);
            // compare registered state of the previous edge
            chk(enc_out_valid == m_ev, "R2 enc_out_valid", 72'(enc_out_valid), 72'(m_ev));
            if (m_ev) chk(enc_out_cw == m_ecw, "R2 R3 enc_out_cw", enc_out_cw, m_ecw);
            chk(enc_in_ready == (!m_ev || enc_out_ready), "R3 enc_in_ready",
                72'(enc_in_ready), 72'(!m_ev || enc_out_ready));
            chk(dec_in_ready == (m_ds == 0), "R9 dec_in_ready", 72'(dec_in_ready), 72'(m_ds == 0));
            chk(dec_out_valid == (m_ds == 2), {m_tag, " dec_out_valid timing"},
                72'(dec_out_valid), 72'(m_ds == 2));
            if (m_ds == 2) begin
                chk(dec_out_data == m_data, {m_tag, " dec_out_data"}, 72'(dec_out_data), 72'(m_data));
                chk(dec_out_corrected == m_corr, {m_tag, " dec_out_corrected"},
                    72'(dec_out_corrected), 72'(m_corr));
                chk(dec_out_uncorrectable == m_unc, {m_tag, " dec_out_uncorrectable"},
                    72'(dec_out_uncorrectable), 72'(m_unc));
            end
            // new stimulus
            enc_in_valid  = ($urandom % 2) == 0;
            case ($urandom % 4)
                0: enc_in_data = '0;
                1: enc_in_data = '1;
                default: enc_in_data = {$urandom, $urandom};
            endcase
            enc_out_ready = ($urandom % 4) != 0;
            if (!have_case) begin
                case_cw   = make_case(case_idx);
                case_idx++;
                have_case = 1'b1;
            end
            dec_in_valid  = ($urandom % 3) != 0;
            dec_in_cw     = case_cw;
            dec_out_ready = ($urandom % 3) != 0;
            // predict the next edge
            if (!m_ev || enc_out_ready) begin
                m_ev = enc_in_valid;
                if (enc_in_valid) m_ecw = 72'(enc_in_data) * 72'd243;
            end
            case (m_ds)
                0: if (dec_in_valid) begin
                    predict(dec_in_cw, m_data, m_corr, m_unc, m_cnt, m_tag);
                    m_ds = 1;
                    have_case = 1'b0;
                end
                1: begin
                    m_cnt--;
                    if (m_cnt == 0) m_ds = 2;
                end
                default: if (dec_out_ready) begin
                    m_ds = 0;
                    n_dec++;
                end
            endcase
        end
        chk(n_dec >= 50, "R9 decode throughput", 72'(n_dec), 72'd50);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule